// File: doc/BRIEF.md
# System Bus Address Region Decoder

This block sits between a single bus master and four fixed targets of a small system-on-chip: a read-only code store, data SRAM, a peripheral window and a system-control window. It looks at each request's address, raises exactly one target select, and passes the write strobe, write data and full address on to the targets. Inside the peripheral window it also gives a slot number that a second-level peripheral mux can use.

Only the top three address bits choose the zone, and only four further bits choose the peripheral slot. The remaining bits are passed through untouched, so a target can be reached at many aliased addresses. A write aimed at the code zone never produces a write strobe. A build-time parameter decides whether such a write completes silently or returns a one-cycle error with its response. Read data comes back one cycle after the address phase. It is steered by a registered copy of the zone select, which matches targets that have a single cycle of read latency.

Top module: `addr_region_decoder`

## Requirements
- R1: Zone decode (`region_sel` bit 0 code, bit 1 SRAM, bit 2 peripheral, bit 3 system): addresses below 0x2000_0000 select the code zone. 0x2000_0000 to 0x3FFF_FFFF select SRAM. 0x4000_0000 to 0xDFFF_FFFF select peripherals. 0xE000_0000 and above select system control.
- R2: While `req_valid` is high exactly one bit of `region_sel` is set. While it is low `region_sel` and `tgt_write` are zero.
- R3: Only address bits [31:29] pick the zone and only bits [19:16] pick the peripheral slot. Two addresses that agree in those bits give identical `region_sel` and `periph_slot`.
- R4: `tgt_write` is never high for a request that selects the code zone.
- R5: With `FAULT_ON_ROM_WRITE`=1, a valid write to the code zone makes `rsp_err` high for exactly the response cycle that follows it, with `rsp_valid` high. No other request raises `rsp_err`.
- R6: With `FAULT_ON_ROM_WRITE`=0, `rsp_err` stays low and a code-zone write still gets an ordinary `rsp_valid` response.
- R7: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R8: `rsp_rdata` in a response cycle equals the read data input of the zone selected one cycle earlier. It is zero after an idle cycle.
- R9: `periph_slot` equals address bits [19:16] when the peripheral zone is selected, and zero otherwise.
- R10: For valid writes outside the code zone `tgt_write` is high. `tgt_addr` and `tgt_wdata` always equal the request address and write data.
- R11: During reset `rsp_valid`, `rsp_err` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| region_sel | output | 4 | One-hot zone select |
| periph_slot | output | 4 | Peripheral slot number, zero outside that zone |
| tgt_write | output | 1 | Write strobe to the selected target |
| tgt_addr | output | 32 | Address forwarded to targets |
| tgt_wdata | output | 32 | Write data forwarded to targets |
| rdata_rom | input | 32 | Read data from code store |
| rdata_ram | input | 32 | Read data from SRAM |
| rdata_periph | input | 32 | Read data from peripheral mux |
| rdata_sys | input | 32 | Read data from system control |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Returned read data |
| rsp_err | output | 1 | Error response for a blocked code write |

## Verification
The only state is the registered zone select and the two response flags, so any corruption shows one cycle after the address phase. It appears either as read data taken from the wrong target or as an error or valid pulse that is missing or misplaced. The bench predicts both the same-cycle select and slot outputs and the next-cycle response on every clock, so a fault appears at the first response that depends on it. A decode fault near a zone boundary only appears for addresses close to that boundary. For that reason the boundary addresses and aliased pairs are driven explicitly, alongside a long pseudo-random run.

// File: rtl/addr_region_decoder.sv
module addr_region_decoder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter bit FAULT_ON_ROM_WRITE = 1'b1,
  parameter int SLOT_LSB = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [3:0]        region_sel,
  output logic [SLOT_W-1:0] periph_slot,
  output logic              tgt_write,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] rdata_rom,
  input  logic [DATA_W-1:0] rdata_ram,
  input  logic [DATA_W-1:0] rdata_periph,
  input  logic [DATA_W-1:0] rdata_sys,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int ZONE_W = 3;

  logic [ZONE_W-1:0] zone;
  logic hit_rom, hit_ram, hit_sys, hit_per, rom_wr;
  logic [3:0] sel_q;

  assign zone    = req_addr[ADDR_W-1 -: ZONE_W];
  assign hit_rom = (zone == 3'b000);
  assign hit_ram = (zone == 3'b001);
  assign hit_sys = (zone == 3'b111);
  assign hit_per = ~(hit_rom | hit_ram | hit_sys);

  assign region_sel  = req_valid ? {hit_sys, hit_per, hit_ram, hit_rom} : 4'b0000;
  assign periph_slot = region_sel[2] ? req_addr[SLOT_LSB +: SLOT_W] : '0;

  assign rom_wr    = req_valid & req_write & hit_rom;
  assign tgt_write = req_valid & req_write & ~hit_rom;
  assign tgt_addr  = req_addr;
  assign tgt_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 4'b0000;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      sel_q     <= region_sel;
      rsp_valid <= req_valid;
      rsp_err   <= FAULT_ON_ROM_WRITE ? rom_wr : 1'b0;
    end
  end

  assign rsp_rdata = ({DATA_W{sel_q[0]}} & rdata_rom)
                   | ({DATA_W{sel_q[1]}} & rdata_ram)
                   | ({DATA_W{sel_q[2]}} & rdata_periph)
                   | ({DATA_W{sel_q[3]}} & rdata_sys);
endmodule

module addr_region_decoder_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        region_sel,
  input logic [SLOT_W-1:0] periph_slot,
  input logic              tgt_write,
  input logic              rsp_valid,
  input logic              rsp_err
);
  AST_ONE_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(region_sel) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (region_sel == 4'b0000 && !tgt_write)); // R2
  AST_ROM_SHIELD: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[0] |-> !tgt_write); // R4
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7
  AST_ERR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(region_sel[0] && req_write)); // R5
  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !region_sel[2] |-> periph_slot == '0); // R9
endmodule

bind addr_region_decoder addr_region_decoder_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/addr_region_decoder_tb.sv
`timescale 1ns/1ps
module addr_region_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] rdata_rom = 32'hC0DE_0001, rdata_ram = 32'h5EA1_0002;
  logic [31:0] rdata_periph = 32'h9E41_0004, rdata_sys = 32'h5C5C_0008;

  logic [3:0] region_sel, region_sel_i, periph_slot, periph_slot_i;
  logic tgt_write, tgt_write_i, rsp_valid, rsp_valid_i, rsp_err, rsp_err_i;
  logic [31:0] tgt_addr, tgt_addr_i, tgt_wdata, tgt_wdata_i, rsp_rdata, rsp_rdata_i;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit pv = 1'b0, pw = 1'b0;
  int pz = 0;

  always #2 clk = ~clk;

  addr_region_decoder #(.FAULT_ON_ROM_WRITE(1'b1)) u_dut (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_wdata,
    .region_sel, .periph_slot, .tgt_write, .tgt_addr, .tgt_wdata,
    .rdata_rom, .rdata_ram, .rdata_periph, .rdata_sys,
    .rsp_valid, .rsp_rdata, .rsp_err);

  addr_region_decoder #(.FAULT_ON_ROM_WRITE(1'b0)) u_dut_ign (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_wdata,
    .region_sel(region_sel_i), .periph_slot(periph_slot_i), .tgt_write(tgt_write_i),
    .tgt_addr(tgt_addr_i), .tgt_wdata(tgt_wdata_i),
    .rdata_rom, .rdata_ram, .rdata_periph, .rdata_sys,
    .rsp_valid(rsp_valid_i), .rsp_rdata(rsp_rdata_i), .rsp_err(rsp_err_i));

  function automatic int zone_of(logic [31:0] a);
    if (a < 32'h2000_0000) return 0;
    if (a < 32'h4000_0000) return 1;
    if (a < 32'hE000_0000) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] rd_of(int z);
    case (z)
      0: return rdata_rom;
      1: return rdata_ram;
      2: return rdata_periph;
      default: return rdata_sys;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, req_addr);
    end
  endtask

  task automatic step(bit v, bit w, logic [31:0] a, logic [31:0] d);
    int z;
    @(negedge clk);
    check("R7 rsp_valid", 64'(rsp_valid), 64'(pv));
    check("R5 rsp_err", 64'(rsp_err), 64'(pv && pw && pz == 0));
    check("R8 rsp_rdata", 64'(rsp_rdata), 64'(pv ? rd_of(pz) : 32'h0));
    check("R6 rsp_err ignore", 64'(rsp_err_i), 64'(0));
    check("R6 rsp_valid ignore", 64'(rsp_valid_i), 64'(pv));
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    #1;
    z = zone_of(a);
    check("R1 region_sel", 64'(region_sel), 64'(v ? (4'b0001 << z) : 4'b0000));
    check("R9 periph_slot", 64'(periph_slot), 64'((v && z == 2) ? ((a >> 16) & 32'hF) : 0));
    check("R4 tgt_write", 64'(tgt_write), 64'(v && w && z != 0));
    check("R10 tgt_addr", 64'(tgt_addr), 64'(a));
    check("R10 tgt_wdata", 64'(tgt_wdata), 64'(d));
    pv = v; pw = w; pz = z;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    logic [3:0] s_a, p_a;
    repeat (3) @(negedge clk);
    check("R11 reset rsp_valid", 64'(rsp_valid), 64'(0));
    check("R11 reset rsp_err", 64'(rsp_err), 64'(0));
    check("R11 reset rsp_rdata", 64'(rsp_rdata), 64'(0));
    rst_n = 1'b1;

    step(1, 0, 32'h0000_0000, 0);           // R1 boundaries
    step(1, 0, 32'h1FFF_FFFF, 0);
    step(1, 0, 32'h2000_0000, 0);
    step(1, 0, 32'h3FFF_FFFC, 0);
    step(1, 0, 32'h4000_0000, 0);
    step(1, 0, 32'hDFFF_FFFF, 0);
    step(1, 0, 32'hE000_0000, 0);
    step(1, 0, 32'hFFFF_FFFF, 0);
    step(0, 0, 32'h2000_0000, 0);           // R2 idle
    step(1, 1, 32'h0000_0010, 32'hDEAD_BEEF); // R4 R5 code write
    step(1, 1, 32'h1234_0000, 32'h1111_2222);  // back-to-back code write
    step(1, 1, 32'h2000_0040, 32'hAAAA_5555);  // R10
    step(1, 1, 32'h4005_1234, 32'h0F0F_0F0F);
    step(1, 1, 32'hE000_E100, 32'h0000_0001);
    step(0, 1, 32'h0000_0000, 0);

    step(1, 0, 32'h4003_0000, 0);           // R3 alias pair
    s_a = region_sel; p_a = periph_slot;
    step(1, 0, 32'hB003_ABCD, 0);
    check("R3 alias zone", 64'(region_sel), 64'(s_a));
    check("R3 alias slot", 64'(periph_slot), 64'(p_a));
    step(1, 0, 32'h2000_0004, 0);
    s_a = region_sel;
    step(1, 0, 32'h3F00_0004, 0);
    check("R3 alias sram", 64'(region_sel), 64'(s_a));

    rnd = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      rnd = rnd * 32'd1664525 + 32'd1013904223;
      rdata_ram = rnd ^ 32'h00FF_00FF;
      step(rnd[3:0] != 4'd0, rnd[5], {rnd[31:29], rnd[12:0], rnd[28:13]}, ~rnd);
    end
    step(0, 0, 0, 0);
    @(negedge clk);
    check("R7 final rsp_valid", 64'(rsp_valid), 64'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule